// File: doc/BRIEF.md
# Prescaled Watchdog Timer with Idle Control

The block is a watchdog that asks for a chip reset when software stops servicing it. The system clock is first divided by a fixed ratio, 12 by default. The divided tick then drives a free-running prescaler. A tap on the prescaler, chosen by a three-bit code, advances a timeout counter. When that counter wraps, the block raises a one-cycle reset request and sets a sticky cause flag. Software clears the cause flag by writing a one.

Software reaches the watchdog through one control word, and that word cannot be read back. The word holds four fields. A start bit turns the watchdog on, and once set it stays set until reset. A restart bit zeroes the whole counting chain and is not stored. An idle-run bit decides whether counting goes on while the processor reports idle. The prescale code sets the division. At power-up the control word is loaded from an option input, so a board can start with the watchdog already running. The reset generator that acts on the request is outside this block, and so is the storage that supplies the option value.

Top module: `wdt_watchdog`

## Requirements
- R1: While `rstN` is low, `wdtResetReq` and `wdtFlag` are 0, and the start, idle-run and prescale settings are taken from `optPreset`. The restart bit of the option value has no effect.
- R2: While the start setting is 0, no overflow occurs, however many cycles pass.
- R3: With prescale code k (0 to 7), an overflow occurs after exactly CLK_DIV × 2^(k+1) × 2^CNT_W counting cycles. Code 0 divides the tick by 2 and code 7 divides it by 256.
- R4: On an overflow, `wdtResetReq` is 1 for exactly one cycle, in the cycle after the counting edge. `wdtFlag` is set at the same edge, and counting carries on from zero.
- R5: A control write with bit 4 (restart) set zeroes the count, and no counting takes place in that cycle. The restart bit is not held, so later cycles count normally.
- R6: While `cpuIdle` is 1 and the idle-run setting is 0, counting pauses. It resumes from the same point when `cpuIdle` falls.
- R7: While the idle-run setting is 1, counting continues whether `cpuIdle` is 0 or 1.
- R8: `flagClr` high at a clock edge clears `wdtFlag`. If an overflow happens at the same edge, the flag is set instead.
- R9: A control write with bit 5 set starts the watchdog. A write with bit 5 clear leaves the start setting unchanged, so only reset can stop the watchdog.
- R10: The control word layout is bit 5 start, bit 4 restart, bit 3 idle-run and bits 2:0 prescale code. Bits 7:6 are ignored. An option value of 0x2D starts the watchdog at power-up with idle-run set and code 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Power-up reset, active low, asynchronous |
| optPreset | input | 8 | Power-up value of the control word |
| ctrlWrEn | input | 1 | Write strobe for the control word |
| ctrlWrData | input | 8 | Control word write data |
| cpuIdle | input | 1 | Processor idle indication |
| flagClr | input | 1 | Write-one strobe that clears the cause flag |
| wdtResetReq | output | 1 | One-cycle chip reset request |
| wdtFlag | output | 1 | Sticky watchdog reset cause flag |

## Verification
The assertions assume that `optPreset` is steady while `rstN` is low. They also assume that a new prescale code arrives only in a write that also restarts the count. A code change in the middle of a count keeps the prescaler's old phase, and the bench model does not follow that. The stimulus therefore always sets the restart bit whenever it changes the code, and it drives every input at the falling clock edge. It uses a small divide ratio and a short counter so that full timeout periods fit in the run.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Control word field positions
  localparam int unsigned ENABLE_BIT  = 5;
  localparam int unsigned RESTART_BIT = 4;
  localparam int unsigned IDLERUN_BIT = 3;
  localparam int unsigned CODE_LSB    = 0;

  // Strobes from control to the counting chain
  typedef struct packed {
    logic run;      // advance the chain this cycle
    logic restart;  // zero the chain this cycle
  } wdt_strobe_t;

endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        optPreset,
  input  logic              ctrlWrEn,
  input  logic [7:0]        ctrlWrData,
  input  logic              cpuIdle,
  output wdt_strobe_t       strobe,
  output logic [CODE_W-1:0] codeSel
);

  logic              enableQ;
  logic              idleRunQ;
  logic [CODE_W-1:0] codeQ;
  logic              restartNow;
  logic              pausedNow;
  logic              unusedBits;

  assign unusedBits = ^{ctrlWrData[7:6], optPreset[7:6], optPreset[RESTART_BIT]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ  <= optPreset[ENABLE_BIT];
      idleRunQ <= optPreset[IDLERUN_BIT];
      codeQ    <= optPreset[CODE_LSB +: CODE_W];
    end else if (ctrlWrEn) begin
      enableQ  <= enableQ | ctrlWrData[ENABLE_BIT];
      idleRunQ <= ctrlWrData[IDLERUN_BIT];
      codeQ    <= ctrlWrData[CODE_LSB +: CODE_W];
    end
  end

  always_comb begin
    restartNow     = ctrlWrEn && ctrlWrData[RESTART_BIT];
    pausedNow      = cpuIdle && !idleRunQ;
    strobe.restart = restartNow;
    strobe.run     = enableQ && !pausedNow && !restartNow;
  end

  assign codeSel = codeQ;

  // R9: the start setting never falls outside reset
  a_r9_enable_sticky: assert property (@(posedge clk) disable iff (!rstN)
    enableQ |=> enableQ);

  // R6: no advance while idle without the idle-run setting
  a_r6_idle_pause: assert property (@(posedge clk) disable iff (!rstN)
    (cpuIdle && !idleRunQ) |-> !strobe.run);

endmodule

// File: rtl/wdt_chain.sv
module wdt_chain
  import wdt_pkg::*;
#(
  parameter int unsigned CLK_DIV = 12,
  parameter int unsigned PRE_W   = 8,
  parameter int unsigned CNT_W   = 15,
  parameter int unsigned CODE_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdt_strobe_t       strobe,
  input  logic [CODE_W-1:0] codeSel,
  input  logic              flagClr,
  output logic              resetReq,
  output logic              causeFlag
);

  localparam int unsigned DIV_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic [DIV_W-1:0] divQ;
  logic [PRE_W-1:0] preQ;
  logic [CNT_W-1:0] cntQ;
  logic [PRE_W-1:0] tapHit;
  logic             baseTick;
  logic             preTick;
  logic             wrapNow;

  // tapHit[i] marks the last tick of a divide-by-2^(i+1) window
  for (genvar i = 0; i < PRE_W; i++) begin : g_tap
    assign tapHit[i] = &preQ[i:0];
  end

  always_comb begin
    baseTick = strobe.run && (divQ == DIV_LAST);
    preTick  = baseTick && tapHit[codeSel];
    wrapNow  = preTick && (&cntQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ <= '0;
      preQ <= '0;
      cntQ <= '0;
    end else if (strobe.restart) begin
      divQ <= '0;
      preQ <= '0;
      cntQ <= '0;
    end else if (strobe.run) begin
      divQ <= baseTick ? '0 : divQ + DIV_W'(1);
      if (baseTick) preQ <= preQ + PRE_W'(1);
      if (preTick)  cntQ <= cntQ + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resetReq  <= 1'b0;
      causeFlag <= 1'b0;
    end else begin
      resetReq <= wrapNow;
      if (wrapNow)      causeFlag <= 1'b1;
      else if (flagClr) causeFlag <= 1'b0;
    end
  end

  // R4: request is a single-cycle pulse
  a_r4_req_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  // R4: a request always comes with the cause flag
  a_r4_flag_with_req: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> causeFlag);

  // R2: the chain holds when neither running nor restarting
  a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.run && !strobe.restart) |=> ($stable(cntQ) && $stable(preQ) && $stable(divQ)));

  // R5: restart leaves the chain at zero
  a_r5_restart_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (cntQ == '0 && divQ == '0 && preQ == '0));

  // R8: a clear strobe drops the flag unless an overflow coincides
  a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rstN)
    flagClr |=> (!causeFlag || resetReq));

endmodule

// File: rtl/wdt_watchdog.sv
module wdt_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned CLK_DIV = 12,
  parameter int unsigned PRE_W   = 8,
  parameter int unsigned CNT_W   = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] optPreset,
  input  logic       ctrlWrEn,
  input  logic [7:0] ctrlWrData,
  input  logic       cpuIdle,
  input  logic       flagClr,
  output logic       wdtResetReq,
  output logic       wdtFlag
);

  localparam int unsigned CODE_W = $clog2(PRE_W);

  wdt_strobe_t       strobe;
  logic [CODE_W-1:0] codeSel;

  wdt_ctrl #(.CODE_W(CODE_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .optPreset  (optPreset),
    .ctrlWrEn   (ctrlWrEn),
    .ctrlWrData (ctrlWrData),
    .cpuIdle    (cpuIdle),
    .strobe     (strobe),
    .codeSel    (codeSel)
  );

  wdt_chain #(
    .CLK_DIV (CLK_DIV),
    .PRE_W   (PRE_W),
    .CNT_W   (CNT_W),
    .CODE_W  (CODE_W)
  ) chain_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .codeSel   (codeSel),
    .flagClr   (flagClr),
    .resetReq  (wdtResetReq),
    .causeFlag (wdtFlag)
  );

endmodule

// File: tb/wdt_watchdog_tb.sv
module wdt_watchdog_tb_top;

  localparam int unsigned TB_DIV = 3;
  localparam int unsigned TB_CNT = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] optPreset = 8'h00;
  logic       ctrlWrEn = 1'b0;
  logic [7:0] ctrlWrData = 8'h00;
  logic       cpuIdle = 1'b0;
  logic       flagClr = 1'b0;
  logic       wdtResetReq;
  logic       wdtFlag;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;

  // reference model state
  bit mEn, mIdleRun, mReq, mFlag;
  int mCode, elapsed;

  always #5 clk = ~clk;

  wdt_watchdog #(.CLK_DIV(TB_DIV), .PRE_W(8), .CNT_W(TB_CNT)) dut_i (
    .clk(clk), .rstN(rstN), .optPreset(optPreset), .ctrlWrEn(ctrlWrEn),
    .ctrlWrData(ctrlWrData), .cpuIdle(cpuIdle), .flagClr(flagClr),
    .wdtResetReq(wdtResetReq), .wdtFlag(wdtFlag)
  );

  function automatic int periodOf(int code);
    return TB_DIV * (1 << (code + 1)) * (1 << TB_CNT);
  endfunction

  task automatic modelEdge();
    bit run;
    if (!rstN) begin
      mEn = optPreset[5]; mIdleRun = optPreset[3]; mCode = optPreset[2:0];
      elapsed = 0; mReq = 0; mFlag = 0;
      return;
    end
    run  = mEn && !(cpuIdle && !mIdleRun);
    mReq = 0;
    if (ctrlWrEn && ctrlWrData[4]) elapsed = 0;
    else if (run) begin
      elapsed++;
      if (elapsed == periodOf(mCode)) begin
        elapsed = 0;
        mReq = 1;
      end
    end
    if (mReq) mFlag = 1;
    else if (flagClr) mFlag = 0;
    if (ctrlWrEn) begin
      mEn      = mEn | ctrlWrData[5];
      mIdleRun = ctrlWrData[3];
      mCode    = ctrlWrData[2:0];
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    vectors++;
    if (wdtResetReq !== mReq) begin
      misses++;
      $display("FAIL %s wdtResetReq=%0b expected %0b at cycle %0d", tag, wdtResetReq, mReq, cycles);
    end
    if (wdtFlag !== mFlag) begin
      misses++;
      $display("FAIL %s wdtFlag=%0b expected %0b at cycle %0d", tag, wdtFlag, mFlag, cycles);
    end
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic writeCtrl(logic [7:0] d, string tag);
    ctrlWrEn = 1'b1; ctrlWrData = d;
    step(tag);
    ctrlWrEn = 1'b0; ctrlWrData = 8'h00;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      misses++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      finishRun();
    end
  end

  initial begin
    // R1: reset state, restart bit of the option ignored
    optPreset = 8'h10;
    run(3, "R1 reset");
    @(negedge clk); rstN = 1'b1;
    // R2: disabled, no overflow
    run(300, "R2 disabled");
    writeCtrl(8'h10, "R2 restart only");
    run(200, "R2 still disabled");
    // R3/R4: code 0, several periods
    writeCtrl(8'h20, "R9 start");
    run(250, "R3 R4 code0 periods");
    // R9: write without start bit keeps running; code 7 period
    writeCtrl(8'h17, "R9 no start bit");
    run(12300, "R3 code7 period");
    // R5: restart keeps overflow away
    writeCtrl(8'h33, "R5 restart code3");
    for (int k = 0; k < 5; k++) begin
      run(700, "R5 serviced");
      writeCtrl(8'h33, "R5 service write");
    end
    run(800, "R5 unserviced overflow");
    // R6: idle pause
    writeCtrl(8'h31, "R6 restart code1");
    run(100, "R6 before idle");
    cpuIdle = 1'b1;
    run(500, "R6 idle paused");
    cpuIdle = 1'b0;
    run(150, "R6 resumed");
    // R7: idle-run keeps counting
    writeCtrl(8'h39, "R7 idle-run");
    cpuIdle = 1'b1;
    run(400, "R7 idle counting");
    cpuIdle = 1'b0;
    // R8: write-one clear, and set winning over clear
    flagClr = 1'b1;
    step("R8 flag clear");
    run(200, "R8 set beats clear");
    flagClr = 1'b0;
    run(20, "R8 after clear");
    // R10: preset start from option, upper bits ignored
    @(negedge clk); rstN = 1'b0; optPreset = 8'hED;
    run(2, "R1 R10 reset preset");
    @(negedge clk); rstN = 1'b1;
    run(3200, "R10 preset running");
    cpuIdle = 1'b1;
    run(3100, "R10 preset idle-run");
    cpuIdle = 1'b0;
    writeCtrl(8'hD0, "R10 upper bits ignored");
    run(3100, "R10 after write");
    finishRun();
  end

endmodule